// File: doc/BRIEF.md
# HDLC Receive Address Filter

This block sits downstream of an HDLC receive deframer. It watches a stream of received octets that carry start-of-frame and end-of-frame markers, and it collects the frame's address field. It then decides whether that address equals one of four programmable compare bytes. The octet stream passes through with a single register stage. Beside it, a per-frame result (valid plus match) comes up once the address field is complete. The result holds until the next frame begins.

The address field is one or two octets long. A two-bit mode selects one of three behaviours: recognition off, where every complete address is accepted; four independent single-byte compare values; or two two-byte compare pairs. The length option, the mode and the four compare bytes are sampled from the configuration inputs only on an initialize pulse. Between pulses, the block runs on its captured copy.

Top module: `hdlc_addr_filter`

## Requirements
- R1: Every input beat appears on the output one clock later, with its data, start marker and end marker unchanged. out_valid_o follows in_valid_i with the same one-cycle delay.
- R2: The length option, the mode and the compare bytes are captured only in a cycle where init_i is high. At any other time, changes on the configuration inputs have no effect on results. After reset the captured configuration is one-octet length, mode 00 and all compare bytes zero.
- R3: Mode encoding is 00 = off, 01 = four single bytes, 10 = two pairs, 11 = reserved. Compare register n (n = 1..4) is cfg_addr_i bits [8n-1:8n-8]. With one-octet length and mode 01, a frame matches when its first octet equals any of the four registers.
- R4: With one-octet length and mode 10, a frame matches when its first octet equals register 1 or register 3.
- R5: With two-octet length and mode 01 or 10, a frame matches only when its first octet equals register 1 and its second equals register 2, or when its first equals register 3 and its second equals register 4.
- R6: In modes 00 and 11, every frame whose address field is complete is reported as matched.
- R7: A frame whose end marker arrives before its address field is complete is reported with res_valid_o high and res_match_o low.
- R8: The result is updated on the clock edge that registers the last address octet. With one-octet length, that is the start octet itself. It then holds through the rest of the frame and through idle cycles. A start octet that does not complete the address clears both res_valid_o and res_match_o.
- R9: res_match_o is never high while res_valid_o is low. Reset clears res_valid_o, res_match_o and out_valid_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| init_i | input | 1 | Capture configuration inputs |
| cfg_two_oct_i | input | 1 | Address length: 0 one octet, 1 two octets |
| cfg_mode_i | input | 2 | Recognition mode |
| cfg_addr_i | input | 32 | Four compare bytes, register 1 in the low byte |
| in_valid_i | input | 1 | Input octet valid |
| in_data_i | input | 8 | Input octet |
| in_sof_i | input | 1 | Octet is the first of a frame |
| in_eof_i | input | 1 | Octet is the last of a frame |
| out_valid_o | output | 1 | Output octet valid |
| out_data_o | output | 8 | Output octet |
| out_sof_o | output | 1 | Delayed start marker |
| out_eof_o | output | 1 | Delayed end marker |
| res_valid_o | output | 1 | Address decision available |
| res_match_o | output | 1 | Frame address matched |

## Verification
Every mode code, both address lengths and every pair of leading octets drawn from the four compare bytes plus one non-member byte are swept. This shows whether a design compares against all four registers, only the pair leaders, or the exact ordered pairs. It also shows whether the reserved code acts as recognition-off. Single-octet frames separate short-frame rejection under two-octet length from a normal match under one-octet length. Configuration changes made without an initialize pulse show whether the shadow copy is really isolated. Idle gaps between frames show whether the result holds until the next start octet.

// File: rtl/hdlc_af_pkg.sv
package hdlc_af_pkg;
  typedef enum logic [1:0] {
    MODE_OFF    = 2'b00,
    MODE_SINGLE = 2'b01,
    MODE_PAIR   = 2'b10,
    MODE_RSVD   = 2'b11
  } haf_mode_e;

  typedef struct packed {
    logic      two_oct;
    haf_mode_e mode;
  } haf_cfg_t;
endpackage

// File: rtl/haf_cfg_shadow.sv
module haf_cfg_shadow #(
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 4,
  localparam int AW = DATA_W * NUM_REGS
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  init_i,
  input  logic                  two_oct_i,
  input  logic [1:0]            mode_i,
  input  logic [AW-1:0]         addr_i,
  output hdlc_af_pkg::haf_cfg_t cfg_o,
  output logic [AW-1:0]         addr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o  <= '{two_oct: 1'b0, mode: hdlc_af_pkg::MODE_OFF};
      addr_o <= '0;
    end else if (init_i) begin
      cfg_o.two_oct <= two_oct_i;
      cfg_o.mode    <= hdlc_af_pkg::haf_mode_e'(mode_i);
      addr_o        <= addr_i;
    end
  end
endmodule

// File: rtl/haf_addr_cmp.sv
module haf_addr_cmp #(
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 4,
  localparam int AW        = DATA_W * NUM_REGS,
  localparam int NUM_PAIRS = NUM_REGS / 2
) (
  input  hdlc_af_pkg::haf_cfg_t cfg_i,
  input  logic [AW-1:0]         addr_i,
  input  logic [DATA_W-1:0]     cur_i,   // octet on the input now
  input  logic [DATA_W-1:0]     held_i,  // first octet of a two-octet address
  output logic                  hit_one_o,
  output logic                  hit_two_o
);
  logic [NUM_REGS-1:0]  single_hit;
  logic [NUM_PAIRS-1:0] lead_hit;
  logic [NUM_PAIRS-1:0] pair_hit;

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_single
    assign single_hit[k] = (cur_i == addr_i[k*DATA_W +: DATA_W]);
  end

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    assign lead_hit[p] = single_hit[2*p];
    assign pair_hit[p] = (held_i == addr_i[(2*p)*DATA_W +: DATA_W]) &&
                         (cur_i  == addr_i[(2*p+1)*DATA_W +: DATA_W]);
  end

  always_comb begin
    unique case (cfg_i.mode)
      hdlc_af_pkg::MODE_SINGLE: begin
        hit_one_o = |single_hit;
        hit_two_o = |pair_hit;
      end
      hdlc_af_pkg::MODE_PAIR: begin
        hit_one_o = |lead_hit;
        hit_two_o = |pair_hit;
      end
      default: begin
        hit_one_o = 1'b1;
        hit_two_o = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/haf_frame_track.sv
module haf_frame_track #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              sof_i,
  input  logic              eof_i,
  input  logic              two_oct_i,
  input  logic              hit_one_i,
  input  logic              hit_two_i,
  output logic [DATA_W-1:0] held_o,
  output logic              res_valid_o,
  output logic              res_match_o
);
  logic in_frame_q;
  logic pend_q;  // waiting for second address octet

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_frame_q  <= 1'b0;
      pend_q      <= 1'b0;
      held_o      <= '0;
      res_valid_o <= 1'b0;
      res_match_o <= 1'b0;
    end else if (valid_i) begin
      if (sof_i) begin
        in_frame_q <= !eof_i;
        if (!two_oct_i) begin
          pend_q      <= 1'b0;
          res_valid_o <= 1'b1;
          res_match_o <= hit_one_i;
        end else if (eof_i) begin
          pend_q      <= 1'b0;
          res_valid_o <= 1'b1;
          res_match_o <= 1'b0;
        end else begin
          pend_q      <= 1'b1;
          held_o      <= data_i;
          res_valid_o <= 1'b0;
          res_match_o <= 1'b0;
        end
      end else if (in_frame_q) begin
        if (pend_q) begin
          pend_q      <= 1'b0;
          res_valid_o <= 1'b1;
          res_match_o <= hit_two_i;
        end
        if (eof_i) in_frame_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/hdlc_addr_filter.sv
module hdlc_addr_filter #(
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 4,
  localparam int AW = DATA_W * NUM_REGS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              init_i,
  input  logic              cfg_two_oct_i,
  input  logic [1:0]        cfg_mode_i,
  input  logic [AW-1:0]     cfg_addr_i,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic              in_sof_i,
  input  logic              in_eof_i,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic              out_sof_o,
  output logic              out_eof_o,
  output logic              res_valid_o,
  output logic              res_match_o
);
  hdlc_af_pkg::haf_cfg_t cfg_q;
  logic [AW-1:0]         addr_q;
  logic [DATA_W-1:0]     held;
  logic                  hit_one;
  logic                  hit_two;

  haf_cfg_shadow #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .init_i    (init_i),
    .two_oct_i (cfg_two_oct_i),
    .mode_i    (cfg_mode_i),
    .addr_i    (cfg_addr_i),
    .cfg_o     (cfg_q),
    .addr_o    (addr_q)
  );

  haf_addr_cmp #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_cmp (
    .cfg_i     (cfg_q),
    .addr_i    (addr_q),
    .cur_i     (in_data_i),
    .held_i    (held),
    .hit_one_o (hit_one),
    .hit_two_o (hit_two)
  );

  haf_frame_track #(.DATA_W(DATA_W)) u_trk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .valid_i     (in_valid_i),
    .data_i      (in_data_i),
    .sof_i       (in_sof_i),
    .eof_i       (in_eof_i),
    .two_oct_i   (cfg_q.two_oct),
    .hit_one_i   (hit_one),
    .hit_two_i   (hit_two),
    .held_o      (held),
    .res_valid_o (res_valid_o),
    .res_match_o (res_match_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
      out_sof_o   <= 1'b0;
      out_eof_o   <= 1'b0;
    end else begin
      out_valid_o <= in_valid_i;
      out_data_o  <= in_data_i;
      out_sof_o   <= in_sof_i;
      out_eof_o   <= in_eof_i;
    end
  end
endmodule

// File: rtl/hdlc_addr_filter_chk.sv
module hdlc_addr_filter_chk #(
  parameter int DATA_W = 8
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  init_i,
  input logic                  in_valid_i,
  input logic [DATA_W-1:0]     in_data_i,
  input logic                  in_sof_i,
  input logic                  in_eof_i,
  input logic                  out_valid_o,
  input logic [DATA_W-1:0]     out_data_o,
  input logic                  res_valid_o,
  input logic                  res_match_o,
  input hdlc_af_pkg::haf_cfg_t cfg_act_i
);
  assert_passthru_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o && out_data_o == $past(in_data_i));

  assert_cfg_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !init_i |=> $stable(cfg_act_i));

  assert_short_frame_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_sof_i && in_eof_i |=> res_valid_o);

  assert_hold_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> $stable(res_valid_o) && $stable(res_match_o));

  assert_match_valid_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_match_o |-> res_valid_o);
endmodule

bind hdlc_addr_filter hdlc_addr_filter_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .init_i      (init_i),
  .in_valid_i  (in_valid_i),
  .in_data_i   (in_data_i),
  .in_sof_i    (in_sof_i),
  .in_eof_i    (in_eof_i),
  .out_valid_o (out_valid_o),
  .out_data_o  (out_data_o),
  .res_valid_o (res_valid_o),
  .res_match_o (res_match_o),
  .cfg_act_i   (cfg_q)
);

// File: tb/hdlc_addr_filter_tb_top.sv
`timescale 1ns/1ps
module hdlc_addr_filter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        init = 1'b0;
  logic        two_oct = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic [31:0] addr = '0;
  logic        iv = 1'b0;
  logic [7:0]  id = '0;
  logic        isof = 1'b0;
  logic        ieof = 1'b0;
  logic        ov, osof, oeof, rv, rm;
  logic [7:0]  od;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  hdlc_addr_filter dut_i (
    .clk_i(clk), .rst_ni(rst_n), .init_i(init),
    .cfg_two_oct_i(two_oct), .cfg_mode_i(mode), .cfg_addr_i(addr),
    .in_valid_i(iv), .in_data_i(id), .in_sof_i(isof), .in_eof_i(ieof),
    .out_valid_o(ov), .out_data_o(od), .out_sof_o(osof), .out_eof_o(oeof),
    .res_valid_o(rv), .res_match_o(rm)
  );

  localparam logic [7:0] REG1 = 8'h11, REG2 = 8'h22, REG3 = 8'h33, REG4 = 8'h44;
  localparam logic [31:0] ADDRS = {REG4, REG3, REG2, REG1};

  function automatic logic [7:0] cand(input int i);
    case (i)
      0: return REG1;
      1: return REG2;
      2: return REG3;
      3: return REG4;
      default: return 8'h55;
    endcase
  endfunction

  function automatic logic exp_match(input logic [1:0] m, input logic t,
                                     input logic [7:0] a0, input logic [7:0] a1);
    if (m == 2'b00 || m == 2'b11) return 1'b1;
    if (t) return (a0 == REG1 && a1 == REG2) || (a0 == REG3 && a1 == REG4);
    if (m == 2'b01) return a0 == REG1 || a0 == REG2 || a0 == REG3 || a0 == REG4;
    return a0 == REG1 || a0 == REG3;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drive at negedge, return at next negedge with outputs updated
  task automatic beat(input logic [7:0] d, input logic s, input logic e);
    iv = 1'b1; id = d; isof = s; ieof = e;
    @(negedge clk);
    iv = 1'b0; isof = 1'b0; ieof = 1'b0;
    chk("R1", {ov, od, osof, oeof}, {1'b1, d, s, e});
  endtask

  task automatic configure(input logic t, input logic [1:0] m, input logic [31:0] a);
    two_oct = t; mode = m; addr = a; init = 1'b1;
    @(negedge clk);
    init = 1'b0;
  endtask

  task automatic frame3(input logic [7:0] a0, input logic [7:0] a1, input logic ex,
                        input logic t, input string req);
    beat(a0, 1'b1, 1'b0);
    if (!t) chk(req, {rv, rm}, {1'b1, ex});
    else    chk("R8", {rv, rm}, 2'b00);
    beat(a1, 1'b0, 1'b0);
    chk(req, {rv, rm}, {1'b1, ex});
    beat(8'h99, 1'b0, 1'b1);
    chk("R8", {rv, rm}, {1'b1, ex});
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9", {ov, rv, rm}, 3'b000);
    rst_n = 1'b1;
    @(negedge clk);

    // reset config: mode off, one octet -> any frame matches
    beat(8'h77, 1'b1, 1'b1);
    chk("R2", {rv, rm}, 2'b11);

    // sweep modes x lengths x leading octets
    for (int m = 0; m < 4; m++) begin
      for (int t = 0; t < 2; t++) begin
        configure(t[0], m[1:0], ADDRS);
        for (int i = 0; i < 5; i++) begin
          for (int j = 0; j < 5; j++) begin
            logic ex;
            string req;
            ex = exp_match(m[1:0], t[0], cand(i), cand(j));
            if (m == 0 || m == 3) req = "R6";
            else if (t == 1)      req = "R5";
            else if (m == 1)      req = "R3";
            else                  req = "R4";
            frame3(cand(i), cand(j), ex, t[0], req);
            if (j == 2) begin
              repeat (2) @(negedge clk);
              chk("R8", {rv, rm}, {1'b1, ex});
            end
          end
        end
      end
    end

    // short frames
    configure(1'b1, 2'b10, ADDRS);
    beat(REG1, 1'b1, 1'b1);
    chk("R7", {rv, rm}, 2'b10);
    configure(1'b1, 2'b00, ADDRS);
    beat(REG3, 1'b1, 1'b1);
    chk("R7", {rv, rm}, 2'b10);
    configure(1'b0, 2'b01, ADDRS);
    beat(REG4, 1'b1, 1'b1);
    chk("R3", {rv, rm}, 2'b11);

    // config changes without init are ignored
    two_oct = 1'b1; mode = 2'b00; addr = 32'hAABBCCDD;
    repeat (3) @(negedge clk);
    frame3(8'h55, REG2, 1'b0, 1'b0, "R2");
    frame3(REG3, 8'h55, 1'b1, 1'b0, "R2");
    frame3(8'hDD, 8'hCC, 1'b0, 1'b0, "R2");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule